// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block sits in front of a shared instruction pipeline. Several hardware thread contexts share that pipeline, and each cycle the block decides which one of them may issue. It keeps one program counter per thread and shows the PC of the chosen thread. When that thread issues, the block moves its PC forward by one instruction word. The pipeline reports two kinds of trouble for each thread: a short stall, which is the ready bit going low, and a long-latency stall, such as a cache miss.

A mode input selects one of two scheduling policies. In interleaved mode a new thread is picked every cycle by round-robin, and any thread that cannot issue is passed over. This hides short stalls behind the other threads. In block mode the current thread keeps the pipeline until it reports a long stall. The block then gives up one cycle: it raises a flush pulse, rewinds the departing thread's PC to its oldest unretired instruction, and moves to the next eligible thread. A redirect port lets the pipeline overwrite any thread's PC, for example after a resolved branch.

Selection is combinational within the cycle. PCs and the record of the last selected thread update on the rising edge.

Top module: `hw_thread_selector`

## Requirements
- R1: While `rst` is high and right after it, `issue_valid` and `flush` are 0, `sel_tid` reads NUM_THREADS-1, and thread i's PC is RESET_PC + i*PC_STRIDE.
- R2: With `mode_coarse`=0, the chosen thread is the first eligible one in round-robin order starting after the last selected thread. Eligible means `ready[i]`=1 and `long_stall[i]`=0, where bit i belongs to thread i. If the last selected thread is the only eligible one, it is chosen again.
- R3: With `mode_coarse`=0 and no eligible thread, `issue_valid` is 0 and `sel_tid` keeps the last selected thread.
- R4: `sel_pc` shows the current PC of `sel_tid`. When `issue_valid` is 1, that thread's PC rises by 4 at the next clock edge.
- R5: With `mode_coarse`=1, `sel_tid` stays on the current thread. If that thread is not ready (a short stall), `issue_valid` is 0 and there is no switch and no flush.
- R6: With `mode_coarse`=1, a long stall on the current thread while another thread is eligible causes a one-cycle `flush`=1 with `issue_valid`=0. On the next cycle `sel_tid` is the next eligible thread in round-robin order after the departing one.
- R7: On that switch, the departing thread's PC is loaded with `oldest_pc`.
- R8: With `mode_coarse`=1, a long stall on the current thread when no other thread is eligible gives no flush and no issue, and the selector stays on the current thread.
- R9: `redirect_valid` loads `redirect_pc` into thread `redirect_tid`'s PC at the clock edge. This load takes priority over the advance and the rewind.
- R10: `issue_valid`=1 only when the selected thread is ready and not long-stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_coarse | input | 1 | 0 = interleave every cycle, 1 = switch on long stall |
| ready | input | NUM_THREADS | Per-thread can-issue bit (low = short stall) |
| long_stall | input | NUM_THREADS | Per-thread long-latency stall report |
| oldest_pc | input | PC_W | Oldest unretired address of the current thread |
| redirect_valid | input | 1 | Load a new PC into one thread |
| redirect_tid | input | TID_W | Thread whose PC is loaded |
| redirect_pc | input | PC_W | Value loaded |
| sel_tid | output | TID_W | Selected thread |
| sel_pc | output | PC_W | PC of the selected thread |
| issue_valid | output | 1 | Selected thread issues this cycle |
| flush | output | 1 | Pipeline flush pulse on a block-mode switch |

## Verification
A wrong last-selected record appears in the next cycle as the wrong `sel_tid` under round-robin order. A wrong PC advance, rewind or redirect shows on `sel_pc` the next time that thread is selected, so the stimulus returns to each thread soon after it touches that thread's PC. In block mode, a missed or extra switch appears on `flush` in the same cycle and as an unexpected `sel_tid` one cycle later.

// File: rtl/hts_pkg.sv
package hts_pkg;

    localparam int INSN_BYTES = 4;

    typedef enum logic {
        SCHED_INTERLEAVE = 1'b0,
        SCHED_BLOCK      = 1'b1
    } sched_mode_e;

    // one-hot decode of a thread index into an N-wide vector
    function automatic logic [63:0] tid_onehot(input int unsigned tid);
        logic [63:0] v;
        v = '0;
        if (tid < 64) v[tid] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/hts_rr_picker.sv
module hts_rr_picker #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic [NUM_THREADS-1:0] eligible,
    input  logic [TID_W-1:0]       base,
    output logic                   found,
    output logic [TID_W-1:0]       pick
);
    // scan base+1 .. base+NUM_THREADS, so base itself has lowest priority
    always_comb begin
        found = 1'b0;
        pick  = base;
        for (int k = 1; k <= NUM_THREADS; k++) begin
            int unsigned idx;
            idx = (int'(base) + k) % NUM_THREADS;
            if (!found && eligible[idx]) begin
                found = 1'b1;
                pick  = idx[TID_W-1:0];
            end
        end
    end
endmodule

// File: rtl/hts_pc_file.sv
module hts_pc_file #(
    parameter int          NUM_THREADS = 4,
    parameter int          PC_W        = 32,
    parameter int          TID_W       = 2,
    parameter logic [31:0] RESET_PC    = 32'h0,
    parameter logic [31:0] PC_STRIDE   = 32'h1000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_THREADS-1:0] adv_en,
    input  logic [NUM_THREADS-1:0] rewind_en,
    input  logic [PC_W-1:0]        rewind_pc,
    input  logic [NUM_THREADS-1:0] load_en,
    input  logic [PC_W-1:0]        load_pc,
    input  logic [TID_W-1:0]       rd_tid,
    output logic [PC_W-1:0]        rd_pc
);
    import hts_pkg::*;

    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    logic [PC_W-1:0] pc_q [NUM_THREADS];

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_ctx
        localparam logic [PC_W-1:0] INIT = PC_W'(RESET_PC + PC_STRIDE * i);

        always_ff @(posedge clk) begin
            if (rst)               pc_q[i] <= INIT;
            else if (load_en[i])   pc_q[i] <= load_pc;
            else if (rewind_en[i]) pc_q[i] <= rewind_pc;
            else if (adv_en[i])    pc_q[i] <= pc_q[i] + STEP;
        end

        assert_redirect_load_R9: assert property (@(posedge clk) disable iff (rst)
            load_en[i] |=> pc_q[i] == $past(load_pc));

        assert_rewind_R7: assert property (@(posedge clk) disable iff (rst)
            (rewind_en[i] && !load_en[i]) |=> pc_q[i] == $past(rewind_pc));

        assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
            (adv_en[i] && !load_en[i] && !rewind_en[i]) |=> pc_q[i] == $past(pc_q[i]) + STEP);
    end

    assign rd_pc = (int'(rd_tid) < NUM_THREADS) ? pc_q[rd_tid] : '0;
endmodule

// File: rtl/hw_thread_selector.sv
module hw_thread_selector #(
    parameter int          NUM_THREADS = 4,
    parameter int          PC_W        = 32,
    parameter logic [31:0] RESET_PC    = 32'h0,
    parameter logic [31:0] PC_STRIDE   = 32'h1000,
    localparam int         TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode_coarse,
    input  logic [NUM_THREADS-1:0] ready,
    input  logic [NUM_THREADS-1:0] long_stall,
    input  logic [PC_W-1:0]        oldest_pc,
    input  logic                   redirect_valid,
    input  logic [TID_W-1:0]       redirect_tid,
    input  logic [PC_W-1:0]        redirect_pc,
    output logic [TID_W-1:0]       sel_tid,
    output logic [PC_W-1:0]        sel_pc,
    output logic                   issue_valid,
    output logic                   flush
);
    import hts_pkg::*;

    localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);

    sched_mode_e mode;
    assign mode = sched_mode_e'(mode_coarse);

    logic [TID_W-1:0] last_q, last_d;
    logic [NUM_THREADS-1:0] eligible, alt_eligible, self_mask;
    logic fine_found, alt_found;
    logic [TID_W-1:0] fine_pick, alt_pick;

    assign eligible     = ready & ~long_stall;
    assign self_mask    = NUM_THREADS'(tid_onehot(int'(last_q)));
    assign alt_eligible = eligible & ~self_mask;

    hts_rr_picker #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_fine_pick (
        .eligible(eligible), .base(last_q), .found(fine_found), .pick(fine_pick));

    hts_rr_picker #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_alt_pick (
        .eligible(alt_eligible), .base(last_q), .found(alt_found), .pick(alt_pick));

    always_comb begin
        last_d      = last_q;
        sel_tid     = last_q;
        issue_valid = 1'b0;
        flush       = 1'b0;
        if (!rst) begin
            if (mode == SCHED_BLOCK) begin
                if (long_stall[last_q]) begin
                    if (alt_found) begin
                        flush  = 1'b1;
                        last_d = alt_pick;
                    end
                end else if (ready[last_q]) begin
                    issue_valid = 1'b1;
                end
            end else if (fine_found) begin
                issue_valid = 1'b1;
                sel_tid     = fine_pick;
                last_d      = fine_pick;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= LAST_TID;
        else     last_q <= last_d;
    end

    logic [NUM_THREADS-1:0] adv_en, rewind_en, load_en;
    assign adv_en    = issue_valid    ? NUM_THREADS'(tid_onehot(int'(sel_tid)))      : '0;
    assign rewind_en = flush          ? self_mask                                    : '0;
    assign load_en   = redirect_valid ? NUM_THREADS'(tid_onehot(int'(redirect_tid))) : '0;

    hts_pc_file #(
        .NUM_THREADS(NUM_THREADS), .PC_W(PC_W), .TID_W(TID_W),
        .RESET_PC(RESET_PC), .PC_STRIDE(PC_STRIDE)
    ) u_pcs (
        .clk(clk), .rst(rst),
        .adv_en(adv_en), .rewind_en(rewind_en), .rewind_pc(oldest_pc),
        .load_en(load_en), .load_pc(redirect_pc),
        .rd_tid(sel_tid), .rd_pc(sel_pc));

    assert_issue_eligible_R10: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (ready[sel_tid] && !long_stall[sel_tid]));

    assert_flush_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!issue_valid && mode_coarse));

    assert_flush_switches_R6: assert property (@(posedge clk) disable iff (rst)
        flush |=> sel_tid != $past(sel_tid));

    assert_block_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_coarse && !flush) |=> (!mode_coarse || sel_tid == $past(sel_tid)));
endmodule

// File: tb/hw_thread_selector_bench.sv
module hw_thread_selector_bench;

    typedef struct packed {
        logic        coarse;
        logic [3:0]  rdy;
        logic [3:0]  lng;
        logic [31:0] old;
        logic        iv;
        logic [1:0]  tid;
        logic        fl;
        logic [31:0] pc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TABLE [NV] = '{
        '{1'b0, 4'b1111, 4'b0000, 32'h0,    1'b1, 2'd0, 1'b0, 32'h0},    // R2 first pick after reset
        '{1'b0, 4'b1111, 4'b0000, 32'h0,    1'b1, 2'd1, 1'b0, 32'h1000}, // R2
        '{1'b0, 4'b1011, 4'b0000, 32'h0,    1'b1, 2'd3, 1'b0, 32'h3000}, // R2 skip not ready
        '{1'b0, 4'b1111, 4'b0001, 32'h0,    1'b1, 2'd1, 1'b0, 32'h1004}, // R2 skip long stall, R4
        '{1'b0, 4'b0000, 4'b0000, 32'h0,    1'b0, 2'd1, 1'b0, 32'h1008}, // R3 idle hold
        '{1'b0, 4'b0100, 4'b0000, 32'h0,    1'b1, 2'd2, 1'b0, 32'h2000}, // R2
        '{1'b0, 4'b0100, 4'b0000, 32'h0,    1'b1, 2'd2, 1'b0, 32'h2004}, // R2 sole repeat, R4
        '{1'b1, 4'b1111, 4'b0000, 32'h0,    1'b1, 2'd2, 1'b0, 32'h2008}, // R5
        '{1'b1, 4'b1011, 4'b0000, 32'h0,    1'b0, 2'd2, 1'b0, 32'h200C}, // R5 short stall
        '{1'b1, 4'b1111, 4'b0100, 32'h2004, 1'b0, 2'd2, 1'b1, 32'h200C}, // R6 switch
        '{1'b1, 4'b1111, 4'b0000, 32'h0,    1'b1, 2'd3, 1'b0, 32'h3004}, // R6 new thread
        '{1'b1, 4'b1111, 4'b1111, 32'h0,    1'b0, 2'd3, 1'b0, 32'h3008}, // R8 no alternative
        '{1'b1, 4'b1111, 4'b0000, 32'h0,    1'b1, 2'd3, 1'b0, 32'h3008}, // R8 stayed
        '{1'b0, 4'b1111, 4'b0000, 32'h0,    1'b1, 2'd0, 1'b0, 32'h4}     // R2 wrap
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_coarse = 1'b0;
    logic [3:0]  ready = '0;
    logic [3:0]  long_stall = '0;
    logic [31:0] oldest_pc = '0;
    logic        redirect_valid = 1'b0;
    logic [1:0]  redirect_tid = '0;
    logic [31:0] redirect_pc = '0;
    logic [1:0]  sel_tid;
    logic [31:0] sel_pc;
    logic        issue_valid;
    logic        flush;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    hw_thread_selector u_hw_thread_selector (
        .clk(clk), .rst(rst), .mode_coarse(mode_coarse), .ready(ready),
        .long_stall(long_stall), .oldest_pc(oldest_pc),
        .redirect_valid(redirect_valid), .redirect_tid(redirect_tid),
        .redirect_pc(redirect_pc), .sel_tid(sel_tid), .sel_pc(sel_pc),
        .issue_valid(issue_valid), .flush(flush));

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 iv in reset", 32'(issue_valid), 32'd0);
        chk("R1 flush in reset", 32'(flush), 32'd0);
        rst = 1'b0;
        #1;
        chk("R1 tid after reset", 32'(sel_tid), 32'd3);
        chk("R1 pc after reset", sel_pc, 32'h3000);
        chk("R1 iv after reset", 32'(issue_valid), 32'd0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            mode_coarse = TABLE[v].coarse;
            ready       = TABLE[v].rdy;
            long_stall  = TABLE[v].lng;
            oldest_pc   = TABLE[v].old;
            #1;
            chk($sformatf("R2/R4/R5/R6/R8 v%0d iv", v), 32'(issue_valid), 32'(TABLE[v].iv));
            chk($sformatf("R2/R3/R5/R6/R8 v%0d tid", v), 32'(sel_tid), 32'(TABLE[v].tid));
            chk($sformatf("R6 v%0d flush", v), 32'(flush), 32'(TABLE[v].fl));
            chk($sformatf("R4/R7 v%0d pc", v), sel_pc, TABLE[v].pc);
            chk($sformatf("R10 v%0d eligibility", v),
                32'(issue_valid && !(ready[sel_tid] && !long_stall[sel_tid])), 32'd0);
        end

        // R7: thread 2 was rewound to 0x2004 during the switch
        @(negedge clk);
        mode_coarse = 1'b0; ready = 4'b0100; long_stall = '0;
        #1;
        chk("R7 rewound pc", sel_pc, 32'h2004);
        chk("R7 tid", 32'(sel_tid), 32'd2);

        // R9: redirect while idle
        @(negedge clk);
        ready = 4'b0000; redirect_valid = 1'b1; redirect_tid = 2'd1; redirect_pc = 32'h8000;
        #1;
        chk("R3 idle iv", 32'(issue_valid), 32'd0);
        @(negedge clk);
        redirect_valid = 1'b0; ready = 4'b0010;
        #1;
        chk("R9 redirected pc", sel_pc, 32'h8000);
        chk("R9 tid", 32'(sel_tid), 32'd1);

        // R9: redirect beats advance on the same thread
        @(negedge clk);
        redirect_valid = 1'b1; redirect_tid = 2'd1; redirect_pc = 32'h9000;
        #1;
        chk("R9 issue during redirect", 32'(issue_valid), 32'd1);
        chk("R4 pc before redirect lands", sel_pc, 32'h8004);
        @(negedge clk);
        redirect_valid = 1'b0;
        #1;
        chk("R9 redirect priority", sel_pc, 32'h9000);

        // R1: reset again restores PCs and selection
        @(negedge clk);
        rst = 1'b1; ready = 4'b1111;
        #1;
        chk("R1 iv gated in reset", 32'(issue_valid), 32'd0);
        @(negedge clk);
        rst = 1'b0; ready = 4'b0010;
        #1;
        chk("R1 pc restored", sel_pc, 32'h1000);

        @(negedge clk);
        finish_run();
    end
endmodule